// File: doc/BRIEF.md
# Three-Wire Handshaking Serial Slave

This block is the slave end of a serial link that runs on three wires: a serial clock and a data line from the master, plus one return line to the master. There is no frame-select wire. All three lines are sampled by a faster system clock. The slave shifts bytes in and out, most significant bit first. The master changes its data when the serial clock rises, and both sides sample when it falls.

While the serial clock is low, the return line carries a status bit instead of data. The master picks which status bit it sees by the level it holds on its own data line. A high level asks whether the slave is ready. A low level asks whether the slave wants attention. The master can restart framing with no extra wire: it raises its data line twice within one clock-low interval.

A received byte that has bit 0 set is a command that needs a handshake. After such a byte the slave reports not-ready until the user logic acknowledges it. The master therefore waits for the slave, but the slave never waits for the master.

Top module: `hs3w_slave`

## Requirements
- R1: While reset is asserted and just after it, miso_out, rx_strobe and rx_byte are all 0.
- R2: Each serial-clock falling edge shifts the synchronized mosi_in level in, most significant bit first. After the eighth falling edge of a byte, rx_byte holds the assembled byte and rx_strobe is high.
- R3: While the serial clock is high, miso_out shows the current transmit bit, most significant bit first. After a framing reset, the first byte sent is the byte most recently captured by tx_load.
- R4: At every byte boundary, the transmit shifter reloads from the captured byte. A tx_load made during a byte takes effect for the next byte.
- R5: While the serial clock is low and mosi_in is high, miso_out equals ready_in AND NOT the handshake hold.
- R6: While the serial clock is low and mosi_in is low, miso_out equals attn_in.
- R7: Two rising edges of mosi_in within one serial-clock-low interval restart the bit count. A partial byte is discarded and produces no strobe, and the transmit shifter reloads.
- R8: A single rising edge of mosi_in in each of several separate clock-low intervals leaves the framing unchanged.
- R9: A received byte with bit 0 = 1 sets the handshake hold, which forces the ready status low until an ack_in pulse. A received byte with bit 0 = 0 leaves ready unchanged.
- R10: rx_strobe is high for exactly one system cycle per received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Serial clock from the master, idles low |
| mosi_in | input | 1 | Data line from the master |
| miso_out | output | 1 | Return line: data bit or status bit |
| rx_byte | output | 8 | Last received byte |
| rx_strobe | output | 1 | One-cycle pulse when rx_byte is new |
| tx_byte | input | 8 | Byte to send to the master |
| tx_load | input | 1 | Captures tx_byte for the next byte boundary |
| ready_in | input | 1 | User logic is ready |
| attn_in | input | 1 | User logic wants attention |
| ack_in | input | 1 | Clears the handshake hold |

## Verification
The bench uses the default values: 8-bit bytes, two synchronizer stages and a reset threshold of two mosi rises. With a two-stage synchronizer, a pin change reaches miso_out after three system cycles. Each serial phase is held for eight system cycles, so every phase can be sampled after it has settled. With a threshold of two, a single status query followed by a second rise in the same clock-low interval is enough to exercise both the no-reset case and the reset case.

// File: rtl/hs3w_pkg.sv
package hs3w_pkg;
  typedef enum logic [1:0] {SRC_DATA, SRC_READY, SRC_ATTN} miso_src_e;

  // selects what the return line carries from the two synchronized master lines
  function automatic miso_src_e pick_src(input logic sclk_hi, input logic mosi_hi);
    if (sclk_hi) return SRC_DATA;
    else if (mosi_hi) return SRC_READY;
    else return SRC_ATTN;
  endfunction

  function automatic logic ready_flag(input logic ready, input logic hold);
    return ready & ~hold;
  endfunction
endpackage

// File: rtl/hs3w_sync.sv
module hs3w_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hs3w_edge.sv
module hs3w_edge #(
  parameter int RST_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic mosi_s,
  output logic sclk_fall,
  output logic mosi_rise,
  output logic frame_rst
);
  localparam int CW = $clog2(RST_EDGES + 1);

  logic          sclk_d, mosi_d;
  logic [CW-1:0] rise_cnt;

  assign sclk_fall = sclk_d & ~sclk_s;
  assign mosi_rise = mosi_s & ~mosi_d;
  // fires once, on the rise that brings the count to the threshold
  assign frame_rst = ~sclk_s & mosi_rise & (rise_cnt == CW'(RST_EDGES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      mosi_d   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk_s;
      mosi_d <= mosi_s;
      if (sclk_s)
        rise_cnt <= '0;
      else if (mosi_rise && rise_cnt != CW'(RST_EDGES))
        rise_cnt <= rise_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hs3w_shift.sv
module hs3w_shift #(
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk_fall,
  input  logic                       mosi_s,
  input  logic                       frame_rst,
  input  logic [BYTE_W-1:0]          tx_byte,
  input  logic                       tx_load,
  input  logic                       ack_in,
  output logic [BYTE_W-1:0]          rx_byte,
  output logic                       rx_strobe,
  output logic                       tx_bit,
  output logic                       hold,
  output logic [$clog2(BYTE_W)-1:0]  bit_cnt,
  output logic                       byte_done
);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] LAST = BW'(BYTE_W - 1);

  logic [BYTE_W-1:0] rx_sh, tx_sh, tx_hold, rx_next;

  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] v, input logic b);
    return {v[BYTE_W-2:0], b};
  endfunction

  assign rx_next   = shift_in(rx_sh, mosi_s);
  assign byte_done = sclk_fall & ~frame_rst & (bit_cnt == LAST);
  assign tx_bit    = tx_sh[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh     <= '0;
      tx_sh     <= '0;
      tx_hold   <= '0;
      rx_byte   <= '0;
      rx_strobe <= 1'b0;
      bit_cnt   <= '0;
      hold      <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      if (tx_load) tx_hold <= tx_byte;
      if (frame_rst) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
        tx_sh   <= tx_hold;
      end else if (sclk_fall) begin
        rx_sh <= rx_next;
        if (bit_cnt == LAST) begin
          bit_cnt   <= '0;
          rx_byte   <= rx_next;
          rx_strobe <= 1'b1;
          tx_sh     <= tx_hold;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          tx_sh   <= tx_sh << 1;
        end
      end
      if (byte_done && rx_next[0]) hold <= 1'b1;
      else if (ack_in)             hold <= 1'b0;
    end
  end
endmodule

// File: rtl/hs3w_slave.sv
module hs3w_slave #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_EDGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              mosi_in,
  output logic              miso_out,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_strobe,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_load,
  input  logic              ready_in,
  input  logic              attn_in,
  input  logic              ack_in
);
  import hs3w_pkg::*;
  localparam int BW = $clog2(BYTE_W);

  logic          sclk_s, mosi_s;
  logic          sclk_fall, mosi_rise, frame_rst;
  logic          tx_bit, hold, byte_done;
  logic [BW-1:0] bit_cnt;

  hs3w_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk_in, mosi_in}), .q({sclk_s, mosi_s})
  );

  hs3w_edge #(.RST_EDGES(RST_EDGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .mosi_s(mosi_s),
    .sclk_fall(sclk_fall), .mosi_rise(mosi_rise), .frame_rst(frame_rst)
  );

  hs3w_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .frame_rst(frame_rst), .tx_byte(tx_byte), .tx_load(tx_load),
    .ack_in(ack_in), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
    .tx_bit(tx_bit), .hold(hold), .bit_cnt(bit_cnt), .byte_done(byte_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) miso_out <= 1'b0;
    else begin
      unique case (pick_src(sclk_s, mosi_s))
        SRC_DATA:  miso_out <= tx_bit;
        SRC_READY: miso_out <= ready_flag(ready_in, hold);
        default:   miso_out <= attn_in;
      endcase
    end
  end
endmodule

// File: rtl/hs3w_slave_chk.sv
module hs3w_slave_chk #(
  parameter int BYTE_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sclk_s,
  input logic                      mosi_s,
  input logic                      sclk_fall,
  input logic                      frame_rst,
  input logic                      hold,
  input logic                      byte_done,
  input logic                      tx_bit,
  input logic [$clog2(BYTE_W)-1:0] bit_cnt,
  input logic                      rx_strobe,
  input logic [BYTE_W-1:0]         rx_byte,
  input logic                      ready_in,
  input logic                      attn_in,
  input logic                      ack_in,
  input logic                      miso_out
);
  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe);
  assert_strobe_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> $past(sclk_fall));
  assert_hold_on_odd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && rx_byte[0]) |-> hold);
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && !byte_done) |=> !hold);
  assert_ready_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_s && mosi_s) |=> (miso_out == $past(ready_in && !hold)));
  assert_attn_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_s && !mosi_s) |=> (miso_out == $past(attn_in)));
  assert_data_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_s |=> (miso_out == $past(tx_bit)));
  assert_reset_low_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rst |-> !sclk_s);
  assert_reset_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rst |=> (bit_cnt == '0 && !rx_strobe));
endmodule

bind hs3w_slave hs3w_slave_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .mosi_s(mosi_s),
  .sclk_fall(sclk_fall), .frame_rst(frame_rst), .hold(hold),
  .byte_done(byte_done), .tx_bit(tx_bit), .bit_cnt(bit_cnt),
  .rx_strobe(rx_strobe), .rx_byte(rx_byte), .ready_in(ready_in),
  .attn_in(attn_in), .ack_in(ack_in), .miso_out(miso_out)
);

// File: tb/sim_hs3w_slave.sv
module sim_hs3w_slave;
  localparam int PH = 8;
  localparam int NV = 6;
  // [15:8] byte the master sends, [7:0] byte the slave must send back
  localparam logic [15:0] VEC [NV] = '{
    16'hA5_3C, 16'h01_F0, 16'h7E_81, 16'hC2_55, 16'hFF_00, 16'h10_E7
  };

  logic clk = 0, rst_n = 0, sclk = 0, mosi = 0;
  logic tx_load = 0, ready = 1, attn = 0, ack = 0;
  logic [7:0] tx_byte = 0;
  logic miso, rx_strobe;
  logic [7:0] rx_byte;
  int checks = 0, errors = 0, n_strobe = 0;
  logic [7:0] last_rx = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hs3w_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .mosi_in(mosi), .miso_out(miso),
    .rx_byte(rx_byte), .rx_strobe(rx_strobe), .tx_byte(tx_byte), .tx_load(tx_load),
    .ready_in(ready), .attn_in(attn), .ack_in(ack)
  );

  always @(negedge clk) if (rst_n && rx_strobe) begin
    n_strobe++;
    last_rx = rx_byte;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_tx(input logic [7:0] b);
    @(negedge clk); tx_byte = b; tx_load = 1;
    @(negedge clk); tx_load = 0;
  endtask

  task automatic send_bit(input logic b, input logic exp, input string tag);
    @(negedge clk); sclk = 1; mosi = b;
    wait_cyc(PH);
    chk(miso == exp, tag, miso, exp);
    sclk = 0;
    wait_cyc(PH);
  endtask

  task automatic frame_reset();
    @(negedge clk); sclk = 0; mosi = 0; wait_cyc(4);
    mosi = 1; wait_cyc(4);
    mosi = 0; wait_cyc(4);
    mosi = 1; wait_cyc(PH);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    wait_cyc(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    wait_cyc(5);
    chk(miso == 0 && rx_strobe == 0 && rx_byte == 0, "R1", {miso, rx_strobe, rx_byte}, 0);
    rst_n = 1;
    wait_cyc(4);
    chk(miso == 0 && n_strobe == 0, "R1 after release", miso, 0);

    // status while clock is low
    attn = 1; wait_cyc(PH);
    chk(miso == 1, "R6 attn high", miso, 1);
    attn = 0; wait_cyc(PH);
    chk(miso == 0, "R6 attn low", miso, 0);
    mosi = 1; wait_cyc(PH);
    chk(miso == 1, "R5 ready high", miso, 1);
    ready = 0; wait_cyc(PH);
    chk(miso == 0, "R5 ready low", miso, 0);
    ready = 1; mosi = 0; wait_cyc(PH);

    // table walk: R2 receive, R3/R4 transmit, R9 handshake, R10 strobe count
    load_tx(VEC[0][7:0]);
    frame_reset();
    for (int k = 0; k < NV; k++) begin
      if (k + 1 < NV) load_tx(VEC[k+1][7:0]);
      base = n_strobe;
      for (int i = 7; i >= 0; i--)
        send_bit(VEC[k][8+i], VEC[k][i], (k == 0) ? "R3 tx bit" : "R4 reloaded tx bit");
      chk(n_strobe == base + 1, "R10 one strobe per byte", n_strobe - base, 1);
      chk(last_rx == VEC[k][15:8], "R2 rx byte", last_rx, VEC[k][15:8]);
      @(negedge clk); mosi = 1; wait_cyc(PH);
      chk(miso == !VEC[k][8], "R9 ready after byte", miso, !VEC[k][8]);
      pulse_ack();
      chk(miso == 1, "R9 ready after ack", miso, 1);
      attn = k[0]; mosi = 0; wait_cyc(PH);
      chk(miso == k[0], "R6 attn between bytes", miso, k[0]);
    end

    // R7: partial byte then framing reset
    load_tx(8'hC3);
    frame_reset();
    base = n_strobe;
    for (int i = 0; i < 3; i++) send_bit(1'b1, (8'hC3 >> (7 - i)) & 1, "R3 partial");
    frame_reset();
    for (int i = 7; i >= 0; i--) send_bit((8'h5A >> i) & 1, (8'hC3 >> i) & 1, "R7 tx restart");
    chk(n_strobe == base + 1, "R7 no strobe for partial", n_strobe - base, 1);
    chk(last_rx == 8'h5A, "R7 rx after restart", last_rx, 8'h5A);

    // R8: one mosi rise in two separate low intervals keeps framing
    load_tx(8'h00);
    frame_reset();
    base = n_strobe;
    for (int i = 7; i >= 4; i--) begin
      send_bit((8'h96 >> i) & 1, 1'b0, "R8 upper");
      @(negedge clk); mosi = 0; wait_cyc(4);
      mosi = 1; wait_cyc(4);
    end
    for (int i = 3; i >= 0; i--) send_bit((8'h96 >> i) & 1, 1'b0, "R8 lower");
    chk(n_strobe == base + 1, "R8 strobe count", n_strobe - base, 1);
    chk(last_rx == 8'h96, "R8 rx byte", last_rx, 8'h96);

    // R9: even byte leaves ready high, hold keeps ready low until ack
    @(negedge clk); mosi = 1; wait_cyc(PH);
    chk(miso == 1, "R9 even byte keeps ready", miso, 1);
    frame_reset();
    for (int i = 7; i >= 0; i--) send_bit((8'h03 >> i) & 1, 1'b0, "R9 cmd byte");
    @(negedge clk); mosi = 1; wait_cyc(3 * PH);
    chk(miso == 0, "R9 hold persists", miso, 0);
    pulse_ack();
    chk(miso == 1, "R9 released", miso, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule